// File: doc/BRIEF.md
# Serial Input Sampling Delay Calibrator

This block tunes the sampling delay placed in front of a serial data input. After a start pulse it steps through four delay codes, from the shortest to the longest, and presents each code on its delay output. With each code in place it issues one read of a fixed test location through a simple request/acknowledge read port. A read that returns the golden pattern marks that code as good. A read that returns anything else marks it as bad, and so does a read that gets no acknowledge within a bounded time. The sweep goes on in both cases.

The four results form a 4-bit good-code mask. The block then maps that mask to the code at the middle of the window of good codes and leaves that code on the delay output. If the good codes do not form one unbroken window, or no code is good, it raises an error flag and puts the delay output back to its reset code. A one-cycle done pulse marks the moment the final code and the error flag are valid. Both then hold until the next start.

Top module: `rxdly_cal`

## Requirements
- R1: Out of reset, `dly_o` equals the reset code (0), and `done_o`, `err_o` and `rd_req_o` are all 0.
- R2: A start pulse in idle runs exactly four test reads, one for each of codes 0, 1, 2 and 3, in ascending order. `dly_o` holds the code under test, and does not change, for as long as its read request is raised.
- R3: While `rd_req_o` is high, `rd_addr_o` equals the test address parameter (default 16'h0014).
- R4: Code i is good, and bit i of the mask is set, only when the acknowledged read data equals 16'h5AA5. Any other value, even one that differs in a single bit, makes the code bad.
- R5: `rd_req_o` stays high until an acknowledge arrives and falls in the cycle after it. An acknowledge that arrives while `rd_req_o` is low has no effect.
- R6: A read that gets no acknowledge within TO_CYC cycles (default 16) ends, counts as bad for that code, and the sweep moves on to the next code.
- R7: The mask is mapped to a final `dly_o` as follows: 1→0, 2→1, 3→0, 4→2, 6→1, 7→1, 8→3, 12→3, 14→2, 15→1. `err_o` is 0 for these masks.
- R8: Masks 0, 5, 9, 10, 11 and 13 set `err_o` to 1 and return `dly_o` to the reset code.
- R9: `done_o` is high for exactly one cycle at the end of a sweep. The final `dly_o` and `err_o` are valid in that cycle and hold until the next start.
- R10: A start pulse that arrives during a sweep is ignored. The sweep still makes exactly four reads and produces the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that starts a calibration sweep |
| rd_req_o | output | 1 | Read request, held until acknowledge or timeout |
| rd_addr_o | output | AW | Address of the test location |
| rd_ack_i | input | 1 | One-cycle read acknowledge with data |
| rd_data_i | input | DW | Read data, valid with `rd_ack_i` |
| dly_o | output | CW | Delay code applied to the serial input |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| err_o | output | 1 | The good codes were not one contiguous window |

## Verification
The bench runs all sixteen good-code masks. Each mask is run once with bad codes answered by corrupted data and once with bad codes left unanswered, and each at two acknowledge latencies. A design that checked the mask bits in a different order, or that stopped the sweep on a timeout, would give a wrong final code or the wrong number of reads. A design that decoded the irregular window centres loosely would miss on 3, 12 or 15, the masks where the centre rounds in different directions. The bench also sends a stray acknowledge while the block is idle and a second start in the middle of a sweep. A design that acted on either would issue extra reads or report a shifted mask.

// File: rtl/rxdly_pkg.sv
package rxdly_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_WAIT,
      ST_DECIDE
   } seq_st_t;

   typedef struct packed {
      logic       ok;
      logic [1:0] code;
   } pick_t;

   // Centre of the contiguous good window for four codes; gaps are invalid.
   function automatic pick_t window_centre(input logic [3:0] m);
      pick_t r;
      r = '{ok: 1'b1, code: 2'd0};
      case (m)
         4'd1:    r.code = 2'd0;
         4'd2:    r.code = 2'd1;
         4'd3:    r.code = 2'd0;
         4'd4:    r.code = 2'd2;
         4'd6:    r.code = 2'd1;
         4'd7:    r.code = 2'd1;
         4'd8:    r.code = 2'd3;
         4'd12:   r.code = 2'd3;
         4'd14:   r.code = 2'd2;
         4'd15:   r.code = 2'd1;
         default: r.ok   = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rxdly_probe.sv
module rxdly_probe #(
   parameter int          DW     = 16,
   parameter logic [DW-1:0] GOLDEN = 16'h5AA5,
   parameter int          TO_CYC = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          ack_i,
   input  logic [DW-1:0] data_i,
   output logic          req_o,
   output logic          fin_o,
   output logic          pass_o
);
   localparam int TW = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;

   logic expire;

   generate
      if (TO_CYC == 0) begin : g_no_timeout
         assign expire = 1'b0;
      end else begin : g_timeout
         logic [TW-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wait_cnt <= '0;
            else if (go_i || !req_o)
               wait_cnt <= '0;
            else
               wait_cnt <= wait_cnt + 1'b1;
         end
         assign expire = (wait_cnt == TW'(TO_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         fin_o  <= 1'b0;
         pass_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            req_o  <= 1'b1;
            pass_o <= 1'b0;
         end else if (req_o) begin
            if (ack_i) begin
               req_o  <= 1'b0;
               fin_o  <= 1'b1;
               pass_o <= (data_i == GOLDEN);
            end else if (expire) begin
               req_o  <= 1'b0;
               fin_o  <= 1'b1;
               pass_o <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/rxdly_pick.sv
module rxdly_pick #(
   parameter int NSET = 4,
   localparam int CW  = $clog2(NSET)
) (
   input  logic [NSET-1:0] mask_i,
   output logic            ok_o,
   output logic [CW-1:0]   code_o
);
   import rxdly_pkg::*;

   generate
      if (NSET == 4) begin : g_four
         pick_t p;
         assign p      = window_centre(mask_i);
         assign ok_o   = p.ok;
         assign code_o = p.code;
      end else begin : g_bad
         $error("rxdly_pick: only four delay codes are supported");
      end
   endgenerate
endmodule

// File: rtl/rxdly_cal.sv
module rxdly_cal #(
   parameter int            DW        = 16,
   parameter int            AW        = 16,
   parameter logic [AW-1:0] TEST_ADDR = 16'h0014,
   parameter logic [DW-1:0] GOLDEN    = 16'h5AA5,
   parameter int            NSET      = 4,
   parameter int            TO_CYC    = 16,
   parameter int            RST_CODE  = 0,
   localparam int           CW        = $clog2(NSET)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic [CW-1:0] dly_o,
   output logic          done_o,
   output logic          err_o
);
   import rxdly_pkg::*;

   localparam logic [CW-1:0] LAST = CW'(NSET - 1);
   localparam logic [CW-1:0] RCODE = CW'(RST_CODE);

   generate
      if (NSET != 4) begin : g_chk_nset
         $error("rxdly_cal: NSET must be 4");
      end
      if (RST_CODE < 0 || RST_CODE >= NSET) begin : g_chk_rst
         $error("rxdly_cal: RST_CODE out of range");
      end
      if (TO_CYC < 0) begin : g_chk_to
         $error("rxdly_cal: TO_CYC must not be negative");
      end
   endgenerate

   seq_st_t         st;
   logic [CW-1:0]   idx;
   logic [NSET-1:0] mask;
   logic            probe_fin, probe_pass;
   logic            pick_ok;
   logic [CW-1:0]   pick_code;

   rxdly_probe #(.DW(DW), .GOLDEN(GOLDEN), .TO_CYC(TO_CYC)) u_probe (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (st == ST_LAUNCH),
      .ack_i  (rd_ack_i),
      .data_i (rd_data_i),
      .req_o  (rd_req_o),
      .fin_o  (probe_fin),
      .pass_o (probe_pass)
   );

   rxdly_pick #(.NSET(NSET)) u_pick (
      .mask_i (mask),
      .ok_o   (pick_ok),
      .code_o (pick_code)
   );

   assign rd_addr_o = TEST_ADDR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         idx    <= '0;
         mask   <= '0;
         dly_o  <= RCODE;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  idx   <= '0;
                  mask  <= '0;
                  dly_o <= '0;
                  err_o <= 1'b0;
                  st    <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: st <= ST_WAIT;
            ST_WAIT: begin
               if (probe_fin) begin
                  mask[idx] <= probe_pass;
                  if (idx == LAST) begin
                     st <= ST_DECIDE;
                  end else begin
                     idx   <= idx + 1'b1;
                     dly_o <= idx + 1'b1;
                     st    <= ST_LAUNCH;
                  end
               end
            end
            ST_DECIDE: begin
               done_o <= 1'b1;
               dly_o  <= pick_ok ? pick_code : RCODE;
               err_o  <= !pick_ok;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxdly_cal_chk.sv
module rxdly_cal_chk #(
   parameter int            AW        = 16,
   parameter logic [AW-1:0] TEST_ADDR = 16'h0014,
   parameter int            CW        = 2,
   parameter int            RST_CODE  = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req_o,
   input logic          rd_ack_i,
   input logic [AW-1:0] rd_addr_o,
   input logic [CW-1:0] dly_o,
   input logic          done_o,
   input logic          err_o
);
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2
   dly_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && $past(rd_req_o)) |-> $stable(dly_o));

   // R3
   addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_addr_o == TEST_ADDR));

   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i) |=> !rd_req_o);

   // R8
   err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (dly_o == CW'(RST_CODE)));

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rd_req_o);
endmodule

bind rxdly_cal rxdly_cal_chk #(
   .AW(AW), .TEST_ADDR(TEST_ADDR), .CW(CW), .RST_CODE(RST_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
   .rd_addr_o(rd_addr_o), .dly_o(dly_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/rxdly_cal_tb.sv
module rxdly_cal_tb;
   localparam int          DW     = 16;
   localparam int          AW     = 16;
   localparam logic [15:0] TADDR  = 16'h0014;
   localparam logic [15:0] GOLD   = 16'h5AA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic        resp_ack = 1'b0;
   logic        stray_ack = 1'b0;
   logic        rd_ack_i;
   logic [DW-1:0] rd_data_i = '0;
   logic [1:0]  dly_o;
   logic        done_o, err_o;

   int n_chk = 0, n_bad = 0, cyc = 0;

   // responder configuration and records
   logic [3:0] good_pat = 4'h0;
   bit         silent_fail = 1'b0;
   int         lat = 1;
   int         wcnt = 0;
   int         nreq = 0;
   int         addr_err = 0;
   int         seq_dly [8];

   assign rd_ack_i = resp_ack | stray_ack;

   always #4 clk = ~clk;

   rxdly_cal u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .dly_o(dly_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Read responder: answers after lat cycles with golden or corrupted data.
   always @(negedge clk) begin
      cyc++;
      resp_ack = 1'b0;
      if (rd_req_o) begin
         if (wcnt == 0) begin
            if (nreq < 8) seq_dly[nreq] = int'(dly_o);
            nreq++;
            if (rd_addr_o != TADDR) addr_err++;
         end
         if (wcnt == lat) begin
            if (good_pat[dly_o]) begin
               resp_ack  = 1'b1;
               rd_data_i = GOLD;
            end else if (!silent_fail) begin
               resp_ack  = 1'b1;
               rd_data_i = GOLD ^ (16'h0001 << (dly_o * 5));
            end
         end
         wcnt++;
      end else begin
         wcnt = 0;
      end
   end

   function automatic void exp_pick(input logic [3:0] m, output bit ok, output int code);
      ok = 1'b1;
      code = 0;
      case (m)
         4'd1: code = 0;  4'd2: code = 1;  4'd3: code = 0;  4'd4: code = 2;
         4'd6: code = 1;  4'd7: code = 1;  4'd8: code = 3;  4'd12: code = 3;
         4'd14: code = 2; 4'd15: code = 1;
         default: ok = 1'b0;
      endcase
   endfunction

   task automatic run(input logic [3:0] pat, input bit silent, input int l, input bit poke);
      bit ok_e;
      int code_e;
      int guard;
      bit saw;
      good_pat = pat;
      silent_fail = silent;
      lat = l;
      nreq = 0;
      addr_err = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      guard = 0;
      saw = 1'b0;
      while (!done_o && guard < 400) begin
         @(negedge clk);
         guard++;
         // R10: second start in the middle of the sweep
         if (poke && nreq == 2 && !saw) begin
            start_i = 1'b1;
            saw = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      start_i = 1'b0;
      exp_pick(pat, ok_e, code_e);
      chk(done_o == 1'b1, "R9 done seen", int'(done_o), 1);
      // R2 four reads, ascending codes
      chk(nreq == 4, poke ? "R10 read count" : "R2 read count", nreq, 4);
      for (int k = 0; k < 4; k++)
         chk(seq_dly[k] == k, "R2 code order", seq_dly[k], k);
      chk(addr_err == 0, "R3 address", addr_err, 0);
      // R4 R6 R7 R8 final result
      if (ok_e) begin
         chk(int'(dly_o) == code_e, silent ? "R6 R7 code" : "R4 R7 code", int'(dly_o), code_e);
         chk(err_o == 1'b0, "R7 err", int'(err_o), 0);
      end else begin
         chk(int'(dly_o) == 0, "R8 code", int'(dly_o), 0);
         chk(err_o == 1'b1, silent ? "R6 R8 err" : "R8 err", int'(err_o), 1);
      end
      @(negedge clk);
      chk(done_o == 1'b0, "R9 pulse width", int'(done_o), 0);
      repeat (3) @(negedge clk);
      chk(int'(dly_o) == (ok_e ? code_e : 0), "R9 hold code", int'(dly_o), ok_e ? code_e : 0);
      chk(err_o == !ok_e, "R9 hold err", int'(err_o), int'(!ok_e));
      chk(nreq == 4 && rd_req_o == 1'b0, "R10 no extra read", nreq, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(dly_o == 2'd0, "R1 dly", int'(dly_o), 0);
      chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
      chk(err_o == 1'b0, "R1 err", int'(err_o), 0);
      chk(rd_req_o == 1'b0, "R1 req", int'(rd_req_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R5 stray acknowledge while idle has no effect
      stray_ack = 1'b1;
      rd_data_i = GOLD;
      @(negedge clk);
      stray_ack = 1'b0;
      repeat (2) @(negedge clk);
      chk(rd_req_o == 1'b0 && done_o == 1'b0, "R5 stray ack", int'(rd_req_o), 0);
      chk(nreq == 0, "R5 stray ack reads", nreq, 0);
      for (int m = 0; m < 16; m++)
         for (int s = 0; s < 2; s++)
            for (int li = 0; li < 2; li++)
               run(4'(m), s[0], (li == 0) ? 1 : 3, (m % 5 == 1) && li == 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule